// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block turns a 32-bit linear address into a physical byte address. When paging is switched on, it walks two tables held in external memory. First it reads one 4-byte entry from a directory. That entry points to a second-level table, and the block reads one 4-byte entry from it. The upper 20 bits of that second entry name the physical frame. Every table address is formed by concatenation. A 4 KB-aligned base has an index placed beside it, followed by two zero bits, so no adder sits in the address path.

A 32-entry fully associative translation cache keeps recent page-number-to-frame pairs. A hit answers in the cycle after the request without touching memory. When paging is off, the linear address comes back unchanged. Only one walk is in flight at a time. The request side stalls while the walk runs. A missing present bit at either level ends the walk with a fault.

The block sits between an address-generating client and a memory port. It issues one-word reads on that port and waits for a single valid-qualified reply to each read.

Top module: `pw_walker`

## Requirements
- R1: Bits 31:22 of the linear address select the directory slot, bits 21:12 select the slot in the second-level table, and bits 11:0 are the byte offset, which appears unchanged as bits 11:0 of every non-faulting result.
- R2: The first read of a walk targets {dir_base[31:12], lin[31:22], 2'b00}; bits 11:0 of dir_base have no effect.
- R3: The second read of a walk targets {first_entry[31:12], lin[21:12], 2'b00}.
- R4: A completed walk returns {second_entry[31:12], lin[11:0]} with the fault flag low.
- R5: Bit 0 of each table entry is the present bit. If it is clear in the directory entry, the walk ends after one read. If it is clear in the second-level entry, the walk ends after two reads. Either way the response carries fault=1 and phys=0, and no cache entry is written, so the same page walks again next time.
- R6: A request accepted with paging_en=0 returns phys equal to the linear address with fault=0 in the next cycle. It issues no memory read and leaves the cache unchanged.
- R7: A request whose page is held in the 32-entry cache returns the cached frame with its own offset in the next cycle, with no memory read.
- R8: Cache fills use slots in round-robin order starting at slot 0 after reset or after a flush, so fill number 33 after a flush replaces the page filled first.
- R9: A one-cycle tlb_flush invalidates every entry. A request accepted in the flush cycle is treated as a miss. A fill that lands in the flush cycle is dropped.
- R10: Only one walk is outstanding. req_ready is low from the cycle after a missing request is accepted until the cycle its response is presented, and the block never issues a read and presents a response in the same cycle.
- R11: Each memory read is a one-cycle mem_req_valid pulse. mem_rsp_valid outside a walk is ignored.
- R12: After reset, req_ready=1, rsp_valid=0, mem_req_valid=0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | 1 = translate, 0 = pass the address through |
| dir_base | input | 32 | Directory base register; bits 31:12 used |
| tlb_flush | input | 1 | Invalidate all cache entries |
| req_valid | input | 1 | Translation request strobe |
| req_lin | input | 32 | Linear address to translate |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault indication |
| mem_req_valid | output | 1 | One-cycle memory read strobe |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Table entry read from memory |

## Verification
The cache flush can fall in the same cycle as either of two cache operations: the lookup of a request being accepted, or the fill written when a walk completes. The bench raises tlb_flush together with req_valid for a page known to be cached, and judges the case by seeing two memory reads instead of a zero-latency hit. It also raises tlb_flush in the very cycle the memory model returns the second-level entry. The result of that walk must still be correct, and an immediate repeat of the page must walk again with two reads, because the fill was dropped. A third request to the page then returns with no reads, since the second walk did fill the cache.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIR  = 2'd1,
    ST_TBL  = 2'd2
  } walk_st_t;

  localparam int PRESENT_BIT = 0;
endpackage

// File: rtl/pw_rr_ptr.sv
module pw_rr_ptr #(
  parameter int DEPTH = 32,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/pw_tlb.sv
module pw_tlb #(
  parameter int DEPTH = 32,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn
);
  logic [VPN_W-1:0] tag_mem [DEPTH];
  logic [PFN_W-1:0] frm_mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] match;
  logic [IDX_W-1:0] victim;
  logic             do_fill;

  assign do_fill = fill_en && !flush;

  pw_rr_ptr #(.DEPTH(DEPTH)) u_rr (
    .clk (clk),
    .rst (rst),
    .clr (flush),
    .adv (do_fill),
    .ptr (victim)
  );

  // Storage arrays carry no reset so they map onto plain memory cells.
  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_mem[victim] <= fill_vpn;
      frm_mem[victim] <= fill_pfn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      vld <= '0;
    end else if (do_fill) begin
      vld[victim] <= 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match[i] = vld[i] && (tag_mem[i] == lk_vpn);
  end

  // A flush in the lookup cycle masks any hit.
  assign lk_hit = (|match) && !flush;

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < DEPTH; i++) begin
      lk_pfn = lk_pfn | (frm_mem[i] & {PFN_W{match[i]}});
    end
  end
endmodule

// File: rtl/pw_addr_fmt.sv
module pw_addr_fmt #(
  parameter int ADDR_W = 32,
  parameter int DIR_W  = 10,
  parameter int TBL_W  = 10,
  parameter int OFF_W  = 12,
  localparam int FRM_W = ADDR_W - OFF_W
) (
  input  logic [FRM_W-1:0]  base_frame,
  input  logic [DIR_W-1:0]  new_dir_idx,
  input  logic [FRM_W-1:0]  ent_frame,
  input  logic [TBL_W-1:0]  held_tbl_idx,
  input  logic [OFF_W-1:0]  held_off,
  output logic [ADDR_W-1:0] dir_ent_addr,
  output logic [ADDR_W-1:0] tbl_ent_addr,
  output logic [ADDR_W-1:0] phys_addr
);
  localparam int DPAD = OFF_W - DIR_W;
  localparam int TPAD = OFF_W - TBL_W;

  // Pure concatenation: the base is 4 KB aligned, the entries are 4 bytes.
  assign dir_ent_addr = {base_frame, new_dir_idx, {DPAD{1'b0}}};
  assign tbl_ent_addr = {ent_frame, held_tbl_idx, {TPAD{1'b0}}};
  assign phys_addr    = {ent_frame, held_off};
endmodule

// File: rtl/pw_walker.sv
module pw_walker
  import pw_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DIR_W     = 10,
  parameter int TBL_W     = 10,
  parameter int OFF_W     = 12,
  parameter int TLB_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              paging_en,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              tlb_flush,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_lin,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic              rsp_fault,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  localparam int FRM_W = ADDR_W - OFF_W;
  localparam int VPN_W = DIR_W + TBL_W;

  walk_st_t          st;
  logic [ADDR_W-1:0] lin_q;
  logic              accept;
  logic              hit;
  logic [FRM_W-1:0]  hit_pfn;
  logic              present;
  logic              fill_en;
  logic [ADDR_W-1:0] dir_ent_addr;
  logic [ADDR_W-1:0] tbl_ent_addr;
  logic [ADDR_W-1:0] walk_phys;
  logic              unused_bits;

  assign unused_bits = ^{dir_base[OFF_W-1:0], mem_rsp_data[OFF_W-1:1]};

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign present   = mem_rsp_data[PRESENT_BIT];
  assign fill_en   = (st == ST_TBL) && mem_rsp_valid && present;

  pw_tlb #(
    .DEPTH (TLB_DEPTH),
    .VPN_W (VPN_W),
    .PFN_W (FRM_W)
  ) u_tlb (
    .clk      (clk),
    .rst      (rst),
    .flush    (tlb_flush),
    .lk_vpn   (req_lin[ADDR_W-1:OFF_W]),
    .lk_hit   (hit),
    .lk_pfn   (hit_pfn),
    .fill_en  (fill_en),
    .fill_vpn (lin_q[ADDR_W-1:OFF_W]),
    .fill_pfn (mem_rsp_data[ADDR_W-1:OFF_W])
  );

  pw_addr_fmt #(
    .ADDR_W (ADDR_W),
    .DIR_W  (DIR_W),
    .TBL_W  (TBL_W),
    .OFF_W  (OFF_W)
  ) u_fmt (
    .base_frame   (dir_base[ADDR_W-1:OFF_W]),
    .new_dir_idx  (req_lin[ADDR_W-1 -: DIR_W]),
    .ent_frame    (mem_rsp_data[ADDR_W-1:OFF_W]),
    .held_tbl_idx (lin_q[OFF_W+TBL_W-1 -: TBL_W]),
    .held_off     (lin_q[OFF_W-1:0]),
    .dir_ent_addr (dir_ent_addr),
    .tbl_ent_addr (tbl_ent_addr),
    .phys_addr    (walk_phys)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      lin_q         <= '0;
      rsp_valid     <= 1'b0;
      rsp_phys      <= '0;
      rsp_fault     <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
    end else begin
      rsp_valid     <= 1'b0;
      mem_req_valid <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            lin_q <= req_lin;
            if (!paging_en) begin
              rsp_valid <= 1'b1;
              rsp_phys  <= req_lin;
              rsp_fault <= 1'b0;
            end else if (hit) begin
              rsp_valid <= 1'b1;
              rsp_phys  <= {hit_pfn, req_lin[OFF_W-1:0]};
              rsp_fault <= 1'b0;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= dir_ent_addr;
              st            <= ST_DIR;
            end
          end
        end
        ST_DIR: begin
          if (mem_rsp_valid) begin
            if (present) begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= tbl_ent_addr;
              st            <= ST_TBL;
            end else begin
              rsp_valid <= 1'b1;
              rsp_phys  <= '0;
              rsp_fault <= 1'b1;
              st        <= ST_IDLE;
            end
          end
        end
        ST_TBL: begin
          if (mem_rsp_valid) begin
            rsp_valid <= 1'b1;
            rsp_phys  <= present ? walk_phys : '0;
            rsp_fault <= !present;
            st        <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_walker_chk.sv
module pw_walker_chk #(
  parameter int ADDR_W = 32,
  parameter int DIR_W  = 10,
  parameter int OFF_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              paging_en,
  input logic [ADDR_W-1:0] dir_base,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_lin,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_phys,
  input logic              rsp_fault,
  input logic              mem_req_valid,
  input logic [ADDR_W-1:0] mem_req_addr
);
  logic [ADDR_W-1:0] acc_lin;
  logic              unused_chk;

  assign unused_chk = ^dir_base[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) acc_lin <= '0;
    else if (req_valid && req_ready) acc_lin <= req_lin;
  end

  // R10: no request can be taken while a read is on the port
  a_r10_ready_low_on_read: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !req_ready);

  // R10: a read and a response never share a cycle
  a_r10_read_or_resp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !mem_req_valid);

  // R11: reads are single-cycle pulses
  a_r11_read_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  // R6: pass-through when paging is off
  a_r6_bypass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !paging_en) |=>
      (rsp_valid && !rsp_fault && rsp_phys == $past(req_lin)));

  // R7: a translating request either answers at once or starts a walk
  a_r7_hit_or_walk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && paging_en) |=> (rsp_valid ^ mem_req_valid));

  // R2: first read address is formed from the base frame and directory index
  a_r2_dir_addr: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && paging_en) |=>
      (!mem_req_valid ||
       mem_req_addr == {$past(dir_base[ADDR_W-1:OFF_W]),
                        $past(req_lin[ADDR_W-1 -: DIR_W]),
                        {(OFF_W-DIR_W){1'b0}}}));

  // R1: offset survives every successful translation
  a_r1_offset: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_fault) |-> (rsp_phys[OFF_W-1:0] == acc_lin[OFF_W-1:0]));

  // R5: faulting responses carry a zero address
  a_r5_fault_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault) |-> (rsp_phys == '0));
endmodule

bind pw_walker pw_walker_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .paging_en     (paging_en),
  .dir_base      (dir_base),
  .req_valid     (req_valid),
  .req_lin       (req_lin),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_phys      (rsp_phys),
  .rsp_fault     (rsp_fault),
  .mem_req_valid (mem_req_valid),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/pw_walker_tb.sv
module pw_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 2;
  localparam logic [31:0] DBASE = 32'h0001_0ABC;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        paging_en = 1'b0;
  logic        flush_main = 1'b0;
  logic        flush_mem = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_lin = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_phys;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        model_rv = 1'b0;
  logic        spur_rv = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int reads = 0;
  int rd_idx = 0;
  logic [31:0] cur_lin = '0;
  bit flush_on_tbl = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_walker u_dut (
    .clk           (clk),
    .rst           (rst),
    .paging_en     (paging_en),
    .dir_base      (DBASE),
    .tlb_flush     (flush_main | flush_mem),
    .req_valid     (req_valid),
    .req_lin       (req_lin),
    .req_ready     (req_ready),
    .rsp_valid     (rsp_valid),
    .rsp_phys      (rsp_phys),
    .rsp_fault     (rsp_fault),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (model_rv | spur_rv),
    .mem_rsp_data  (mem_rsp_data)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pde_of(input int d);
    return {20'(32'h300 + d), (d % 7 == 3) ? 12'hFFE : 12'hC01};
  endfunction

  function automatic logic [31:0] pte_of(input int d, input int t);
    logic [19:0] frame;
    frame = 20'((d * 1024 + t) ^ 32'h5A5A5);
    return {frame, (t % 11 == 5) ? 12'hFFE : 12'h003};
  endfunction

  function automatic logic [31:0] mk_lin(input int d, input int t, input int off);
    return {10'(d), 10'(t), 12'(off)};
  endfunction

  // Memory model: one response LAT cycles after each read pulse.
  initial begin
    forever begin
      @(negedge clk);
      model_rv  = 1'b0;
      flush_mem = 1'b0;
      if (mem_req_valid) begin
        int d, t;
        logic [31:0] ptr;
        d = int'(cur_lin[31:22]);
        t = int'(cur_lin[21:12]);
        reads++;
        if (rd_idx == 0) begin
          chk(mem_req_addr == {DBASE[31:12], cur_lin[31:22], 2'b00}, "R2",
              "directory read address", mem_req_addr, {DBASE[31:12], cur_lin[31:22], 2'b00});
          ptr = pde_of(d);
        end else begin
          chk(mem_req_addr == {20'(32'h300 + d), cur_lin[21:12], 2'b00}, "R3",
              "table read address", mem_req_addr, {20'(32'h300 + d), cur_lin[21:12], 2'b00});
          ptr = pte_of(d, t);
        end
        rd_idx++;
        repeat (LAT - 1) @(negedge clk);
        model_rv     = 1'b1;
        mem_rsp_data = ptr;
        if (flush_on_tbl && rd_idx == 2) begin
          flush_mem    = 1'b1;
          flush_on_tbl = 1'b0;
        end
      end
    end
  end

  task automatic xlate(input logic [31:0] lin, input bit pe, input bit fl,
                       input logic [31:0] ephys, input bit efault,
                       input int ereads, input string rq);
    int cyc;
    int r0;
    bit ready_bad;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_lin    = lin;
    rd_idx     = 0;
    r0         = reads;
    paging_en  = pe;
    req_lin    = lin;
    req_valid  = 1'b1;
    flush_main = fl;
    @(negedge clk);
    req_valid  = 1'b0;
    flush_main = 1'b0;
    cyc = 1;
    ready_bad = 1'b0;
    while (!rsp_valid && cyc < 200) begin
      if (req_ready) ready_bad = 1'b1;
      @(negedge clk);
      cyc++;
    end
    chk(rsp_valid, rq, "response present", 32'(rsp_valid), 32'd1);
    chk(rsp_phys == ephys, rq, "physical address", rsp_phys, ephys);
    chk(rsp_fault == efault, rq, "fault flag", 32'(rsp_fault), 32'(efault));
    chk(reads - r0 == ereads, rq, "memory reads", 32'(reads - r0), 32'(ereads));
    if (ereads == 0) chk(cyc == 1, rq, "one-cycle latency", 32'(cyc), 32'd1);
    else chk(!ready_bad, "R10", "req_ready low during walk", 32'(ready_bad), 32'd0);
  endtask

  // Translate with paging on; expected values from the entry functions.
  task automatic walk(input logic [31:0] lin, input bit cached, input bit fl,
                      input string rq);
    int d, t, nr;
    logic [31:0] ph;
    bit f;
    d = int'(lin[31:22]);
    t = int'(lin[21:12]);
    if (d % 7 == 3) begin
      f = 1'b1; ph = '0; nr = 1;
    end else if (t % 11 == 5) begin
      f = 1'b1; ph = '0; nr = 2;
    end else begin
      f = 1'b0; ph = {pte_of(d, t)[31:12], lin[11:0]}; nr = 2;
    end
    if (cached) nr = 0;
    xlate(lin, 1'b1, fl, ph, f, nr, rq);
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush_main = 1'b1;
    @(negedge clk);
    flush_main = 1'b0;
  endtask

  initial begin
    int dl[7];
    int tl[5];
    dl = '{0, 1, 3, 5, 10, 512, 1023};
    tl = '{0, 5, 7, 300, 1023};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(req_ready == 1'b1, "R12", "req_ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R12", "rsp_valid after reset", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R12", "mem_req_valid after reset", 32'(mem_req_valid), 32'd0);
    // R12: empty cache, first translation walks
    walk(mk_lin(2, 2, 16), 1'b0, 1'b0, "R12");

    // R6: pass-through
    xlate(32'hDEAD_BEEF, 1'b0, 1'b0, 32'hDEAD_BEEF, 1'b0, 0, "R6");
    xlate(32'h0000_0000, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 0, "R6");

    // R1 R2 R3 R4 R5: sweep over directory and table slots
    foreach (dl[i]) begin
      foreach (tl[j]) begin
        walk(mk_lin(dl[i], tl[j], (dl[i] * 37 + tl[j] * 13) & 12'hFFF), 1'b0, 1'b0, "R4");
      end
    end

    // R7: hits after a flush and refill; R5: faulting pages are not cached
    pulse_flush();
    walk(mk_lin(1, 7, 12'h123), 1'b0, 1'b0, "R7");
    walk(mk_lin(5, 0, 12'h000), 1'b0, 1'b0, "R7");
    walk(mk_lin(1, 7, 12'hFFF), 1'b1, 1'b0, "R7");
    walk(mk_lin(5, 0, 12'h9A0), 1'b1, 1'b0, "R7");
    walk(mk_lin(3, 1, 12'h010), 1'b0, 1'b0, "R5");
    walk(mk_lin(3, 1, 12'h010), 1'b0, 1'b0, "R5");
    walk(mk_lin(6, 5, 12'h020), 1'b0, 1'b0, "R5");
    walk(mk_lin(6, 5, 12'h020), 1'b0, 1'b0, "R5");
    // R6: bypass of a cached page returns the linear address
    xlate(mk_lin(1, 7, 12'h456), 1'b0, 1'b0, mk_lin(1, 7, 12'h456), 1'b0, 0, "R6");
    walk(mk_lin(1, 7, 12'h457), 1'b1, 1'b0, "R6");

    // R8: round-robin replacement from slot 0 after a flush
    pulse_flush();
    for (int i = 0; i < 33; i++) walk(mk_lin(7 * i, 2, i), 1'b0, 1'b0, "R8");
    walk(mk_lin(7, 2, 12'h0AA), 1'b1, 1'b0, "R8");
    walk(mk_lin(0, 2, 12'h0AB), 1'b0, 1'b0, "R8");
    walk(mk_lin(14, 2, 12'h0AC), 1'b1, 1'b0, "R8");
    walk(mk_lin(7, 2, 12'h0AD), 1'b0, 1'b0, "R8");

    // R9: flush in the accept cycle turns a hit into a miss, and clears all
    walk(mk_lin(14, 2, 12'h111), 1'b0, 1'b1, "R9");
    walk(mk_lin(21, 2, 12'h112), 1'b0, 1'b0, "R9");
    // R9: flush coinciding with the fill drops the fill
    pulse_flush();
    flush_on_tbl = 1'b1;
    walk(mk_lin(35, 9, 12'h777), 1'b0, 1'b0, "R9");
    walk(mk_lin(35, 9, 12'h778), 1'b0, 1'b0, "R9");
    walk(mk_lin(35, 9, 12'h779), 1'b1, 1'b0, "R9");

    // R11: a stray memory reply while idle has no effect
    @(negedge clk);
    spur_rv = 1'b1;
    mem_rsp_data = 32'hFFFF_F001;
    @(negedge clk);
    spur_rv = 1'b0;
    chk(rsp_valid == 1'b0, "R11", "no response from stray reply", 32'(rsp_valid), 32'd0);
    chk(req_ready == 1'b1, "R11", "still idle after stray reply", 32'(req_ready), 32'd1);
    walk(mk_lin(35, 9, 12'h77A), 1'b1, 1'b0, "R11");
    walk(mk_lin(40, 40, 12'h001), 1'b0, 1'b0, "R11");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule